// File: doc/BRIEF.md
# 5x5 Streaming Window Generator

This block sits in front of a 5x5 convolution engine. Pixels arrive one per clock in raster order, each with its column index. The block keeps the four most recent image rows in four column-addressed line stores and holds a 5x5 register window. Each accepted pixel completes a new 25-element neighbourhood. The window shifts one column to the left, and a freshly formed column enters on the right. That column holds the new pixel at the bottom and the line-store contents at the same column above it, with the oldest row at the top.

A window-valid flag marks the cycles in which all 25 elements come from the current frame and from the same five columns. This needs four complete rows and at least five pixels of the current row. A frame-start strobe discards the row history, so contents left over from an earlier frame never appear as a valid window. The image width is a parameter. Padding at the borders and multi-channel data are not handled here.

Top module: `win5_window_gen`

## Requirements
- R1: After reset, `win_valid` is 0 and every element of `win_data` is 0.
- R2: One cycle after a pixel is accepted (`pix_valid`=1), window element row 4 col 4 holds that pixel. Element (r,c) sits at `win_data[(r*5+c)*DATA_W +: DATA_W]`, where row 0 is the top (oldest) row and col 4 is the rightmost (newest) column.
- R3: One cycle after a pixel at column C is accepted, element (r,4) for r=0..3 holds the pixel that arrived at column C of the row (4-r) rows earlier.
- R4: On each accepted pixel, element (r,c) for c=0..3 takes the value that element (r,c+1) held before.
- R5: `win_valid` is a registered flag. It is 1 one cycle after an accepted pixel whose column is at least 4, provided at least four full rows of the current frame came before it, and it is 0 otherwise.
- R6: In a cycle with `pix_valid`=0, the window does not change, and `win_valid` is 0 in the following cycle.
- R7: `frame_start`=1 clears the count of completed rows, and the pixel presented in that same cycle counts as row 0. After it, no valid window appears until four full rows of the new frame have been received.
- R8: Pixels presented on consecutive clocks are each absorbed in one cycle: a full frame of H rows produces exactly (H-4)*(IMG_W-4) valid windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Marks the first pixel of a frame; clears row history |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_data | input | DATA_W | Pixel value |
| pix_col | input | COL_W | Column index of the pixel, 0 to IMG_W-1 |
| win_data | output | 25*DATA_W | 5x5 window, element (r,c) at bits (r*5+c)*DATA_W |
| win_valid | output | 1 | Window contents form a complete in-frame neighbourhood |

## Verification
The bench compares every window against an image model and checks the top row against pixels from exactly four rows back. A line-store cascade that is off by one row, or a column that enters upside down, shows up as a wrong element. The valid flag is checked at the column-4 boundary and at the start of the fifth row, where an off-by-one count would produce one window too many or too few. Idle cycles are mixed into the stream: a window that shifts on an idle cycle, or a flag that stays high, fails there. A frame restarted after three rows checks that leftover rows never produce a valid window.

// File: rtl/win5_pkg.sv
// Shared geometry constants for the 5x5 window generator.
// Assumes a square window; the row count also sets the line-store count.
package win5_pkg;
    localparam int WIN_ROWS  = 5;
    localparam int WIN_COLS  = 5;
    localparam int WIN_TAPS  = WIN_ROWS * WIN_COLS;
    localparam int LINE_CNT  = WIN_ROWS - 1;
    localparam int FIRST_COL = WIN_COLS - 1;
endpackage

// File: rtl/win5_line_store.sv
// One row-long line store addressed by column.
// Reads combinationally and writes on the clock edge, so a read of the old
// value and a write of the new value at the same column fit in one cycle.
// Assumes addr_i < DEPTH whenever we_i is set.
module win5_line_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Value held at the addressed column before this cycle's write.
    assign rdata_o = mem[addr_i];

    // Store the incoming value at the addressed column.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/win5_shift_window.sv
// 5x5 register window that shifts one column left on every enable and
// loads a new right-hand column. col_i row r feeds window row r; row 4 is
// the newest pixel. Output element (r,c) is at bits (r*5+c)*DATA_W.
module win5_shift_window
    import win5_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic [WIN_ROWS*DATA_W-1:0] col_i,
    output logic [WIN_TAPS*DATA_W-1:0] win_o
);
    logic [DATA_W-1:0] w [WIN_ROWS][WIN_COLS];

    // Shift columns left and insert the new column on the right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < WIN_ROWS; r++) begin
                for (int c = 0; c < WIN_COLS; c++) begin
                    w[r][c] <= '0;
                end
            end
        end else if (shift_en) begin
            for (int r = 0; r < WIN_ROWS; r++) begin
                for (int c = 0; c < WIN_COLS - 1; c++) begin
                    w[r][c] <= w[r][c+1];
                end
                w[r][WIN_COLS-1] <= col_i[r*DATA_W +: DATA_W];
            end
        end
    end

    // Flatten the window onto the output bus.
    always_comb begin
        for (int r = 0; r < WIN_ROWS; r++) begin
            for (int c = 0; c < WIN_COLS; c++) begin
                win_o[(r*WIN_COLS+c)*DATA_W +: DATA_W] = w[r][c];
            end
        end
    end

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !shift_en) |=> $stable(win_o));

    p_newest_corner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && shift_en) |=> (w[WIN_ROWS-1][WIN_COLS-1] == $past(col_i[(WIN_ROWS-1)*DATA_W +: DATA_W])));

    for (genvar gr = 0; gr < WIN_ROWS; gr++) begin : g_chk_row
        for (genvar gc = 0; gc < WIN_COLS - 1; gc++) begin : g_chk_col
            p_shift_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && shift_en) |=> (w[gr][gc] == $past(w[gr][gc+1])));
        end
    end
endmodule

// File: rtl/win5_row_track.sv
// Counts completed rows of the current frame (saturating at four) and
// raises the window-valid flag one cycle after a pixel that completes an
// in-frame 5x5 neighbourhood. frame_start makes the pixel presented with it
// row 0. Assumes rows are sent whole and in raster order.
module win5_row_track
    import win5_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int COL_W = $clog2(IMG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [COL_W-1:0] pix_col,
    output logic             win_valid
);
    localparam logic [2:0]       ROWS_FULL = 3'(LINE_CNT);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(IMG_W - 1);
    localparam logic [COL_W-1:0] MIN_COL   = COL_W'(FIRST_COL);

    logic [2:0] rows_q;
    logic [2:0] rows_eff;
    logic       row_end;

    // Row count seen by this cycle's pixel after any frame restart.
    always_comb begin
        rows_eff = frame_start ? 3'd0 : rows_q;
        row_end  = pix_valid && (pix_col == LAST_COL);
    end

    // Advance the row count and register the window-valid decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q    <= '0;
            win_valid <= 1'b0;
        end else begin
            win_valid <= pix_valid && (rows_eff == ROWS_FULL) && (pix_col >= MIN_COL);
            if (row_end && rows_eff != ROWS_FULL) begin
                rows_q <= rows_eff + 3'd1;
            end else begin
                rows_q <= rows_eff;
            end
        end
    end

    p_rows_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rows_q <= ROWS_FULL);

    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && frame_start && !row_end) |=> (rows_q == 3'd0));

    p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !frame_start && !pix_valid) |=> !win_valid);
endmodule

// File: rtl/win5_window_gen.sv
// Streaming 5x5 window generator. Four column-addressed line stores keep
// the last four rows; each accepted pixel reads them at its column, forms a
// five-entry column (oldest row on top, new pixel at the bottom), shifts it
// into the window and cascades the line stores at that column.
// Assumes raster-order input with pix_col < IMG_W.
module win5_window_gen
    import win5_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IMG_W  = 16,
    parameter int COL_W  = $clog2(IMG_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic                       pix_valid,
    input  logic [DATA_W-1:0]          pix_data,
    input  logic [COL_W-1:0]           pix_col,
    output logic [WIN_TAPS*DATA_W-1:0] win_data,
    output logic                       win_valid
);
    // tap[0] is the new pixel, tap[k] is line store k at this column.
    logic [DATA_W-1:0]          tap [LINE_CNT+1];
    logic [WIN_ROWS*DATA_W-1:0] new_col;

    assign tap[0] = pix_data;

    for (genvar k = 1; k <= LINE_CNT; k++) begin : g_line
        win5_line_store #(
            .DATA_W (DATA_W),
            .DEPTH  (IMG_W),
            .ADDR_W (COL_W)
        ) u_store (
            .clk     (clk),
            .we_i    (pix_valid),
            .addr_i  (pix_col),
            .wdata_i (tap[k-1]),
            .rdata_o (tap[k])
        );
    end

    // Order the column so the oldest row lands in window row 0.
    always_comb begin
        for (int r = 0; r < WIN_ROWS; r++) begin
            new_col[r*DATA_W +: DATA_W] = tap[LINE_CNT - r];
        end
    end

    win5_shift_window #(
        .DATA_W (DATA_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pix_valid),
        .col_i    (new_col),
        .win_o    (win_data)
    );

    win5_row_track #(
        .IMG_W (IMG_W),
        .COL_W (COL_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .pix_col     (pix_col),
        .win_valid   (win_valid)
    );

    p_col_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_col < COL_W'(IMG_W - 1) || pix_col == COL_W'(IMG_W - 1)));

    p_cascade_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pix_valid) |=> (win_data[(3*WIN_COLS+4)*DATA_W +: DATA_W] == $past(tap[1])));
endmodule

// File: tb/win5_window_gen_tb.sv
module win5_window_gen_tb;
    localparam int DW   = 8;
    localparam int W    = 16;
    localparam int CW   = 4;
    localparam int MAXR = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_start = 1'b0;
    logic            pix_valid = 1'b0;
    logic [DW-1:0]   pix_data = '0;
    logic [CW-1:0]   pix_col = '0;
    logic [25*DW-1:0] win_data;
    logic            win_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [DW-1:0] img [MAXR][W];
    logic [25*DW-1:0] last_win;
    int valid_seen;

    always #2 clk = ~clk;

    win5_window_gen #(.DATA_W(DW), .IMG_W(W), .COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_col(pix_col),
        .win_data(win_data), .win_valid(win_valid)
    );

    function automatic logic [DW-1:0] pv(int f, int r, int c);
        return DW'(f * 53 + r * 29 + c * 7 + 3);
    endfunction

    function automatic logic [DW-1:0] el(int r, int c);
        return win_data[(r*5+c)*DW +: DW];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one pixel, wait for the edge, then compare against the model.
    task automatic send(int f, int r, int c, bit fs);
        bit exp_v;
        pix_valid   = 1'b1;
        pix_data    = pv(f, r, c);
        pix_col     = CW'(c);
        frame_start = fs;
        img[r][c]   = pv(f, r, c);
        @(posedge clk);
        #1;
        pix_valid   = 1'b0;
        frame_start = 1'b0;
        exp_v = (r >= 4) && (c >= 4);
        check(win_valid == exp_v, "R5", $sformatf("valid r%0d c%0d", r, c), int'(win_valid), int'(exp_v));
        if (win_valid) valid_seen++;
        check(el(4, 4) == pv(f, r, c), "R2", "bottom-right", int'(el(4, 4)), int'(pv(f, r, c)));
        if (exp_v) begin
            for (int i = 0; i < 4; i++) begin
                check(el(i, 4) == img[r-4+i][c], "R3", $sformatf("col4 row%0d", i),
                      int'(el(i, 4)), int'(img[r-4+i][c]));
            end
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 4; j++) begin
                    check(el(i, j) == img[r-4+i][c-4+j], "R4", $sformatf("el %0d,%0d", i, j),
                          int'(el(i, j)), int'(img[r-4+i][c-4+j]));
                end
            end
        end
        last_win = win_data;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        check(win_data == last_win, "R6", "window held on idle", 0, 0);
        check(win_valid == 1'b0, "R6", "valid low on idle", int'(win_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(win_valid == 1'b0, "R1", "valid after reset", int'(win_valid), 0);
        check(win_data == '0, "R1", "window after reset", 0, 0);
    endtask

    task automatic t_full_frame();
        valid_seen = 0;
        for (int r = 0; r < MAXR; r++)
            for (int c = 0; c < W; c++)
                send(0, r, c, (r == 0 && c == 0));
        check(valid_seen == (MAXR - 4) * (W - 4), "R8", "valid windows per frame",
              valid_seen, (MAXR - 4) * (W - 4));
    endtask

    task automatic t_restart();
        valid_seen = 0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < W; c++)
                send(1, r, c, (r == 0 && c == 0));
        check(valid_seen == 0, "R7", "no valid in short frame", valid_seen, 0);
        valid_seen = 0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < W; c++)
                send(2, r, c, (r == 0 && c == 0));
        check(valid_seen == 2 * (W - 4), "R7", "valid after restart", valid_seen, 2 * (W - 4));
    endtask

    task automatic t_gaps();
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < W; c++) begin
                send(3, r, c, (r == 0 && c == 0));
                if ((c % 3) == 2) idle();
            end
    endtask

    initial begin
        t_reset();
        t_full_frame();
        t_restart();
        t_gaps();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule